// File: doc/BRIEF.md
# Byte FIFO with Water-Level Alerts

This block is a 64-entry, byte-wide first-in first-out buffer that sits between a host register port and an internal transmit/receive engine. Either side pushes bytes in and pops them out through simple single-cycle strobes. The block keeps a running count of stored bytes. It compares that count against a programmable water level to raise an "almost full" alert and an "almost empty" alert.

A write to a full buffer is dropped, and it sets a sticky overflow error. Only the flush strobe clears that error. Flush empties the buffer, resets both pointers and clears the error in a single edge. Each alert has its own interrupt request flag. The flag is set when its alert rises and stays set until the matching clear strobe.

Top module: `txrx_byte_fifo`

## Requirements
- R1: After synchronous reset: level is 0, empty is 1, full is 0, ovfl_err is 0, both interrupt flags are 0, and rd_data is 00h.
- R2: Bytes leave in the order they were written. rd_data takes the oldest byte on the same clock edge that accepts rd_en, and holds it until the next read. level counts the stored bytes from 0 to 64, and full is 1 exactly when level is 64.
- R3: hi_alert is 1 exactly when (64 - level) <= water_lvl. lo_alert is 1 exactly when level <= water_lvl. Both follow the current level and water_lvl with no added delay.
- R4: A write while full is dropped: no stored byte changes, and ovfl_err becomes 1 on that edge. If a read comes in the same cycle, the read still completes, so level becomes 63.
- R5: ovfl_err, once set, stays 1 through reads, writes and idle cycles until a flush.
- R6: On an edge with flush high, level becomes 0, ovfl_err becomes 0, both pointers return to the start, and any read or write in that cycle is ignored.
- R7: A read from an empty buffer with no write in the same cycle sets rd_data to 00h and leaves level at 0.
- R8: A read and a write in the same cycle, when the buffer is neither empty nor full, leave level unchanged. The read returns the oldest byte, and the written byte joins the tail.
- R9: An interrupt flag is set on the edge after its alert goes from 0 to 1, and it stays set until its clear input is high at an edge. A rising alert wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push request |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 8 | Last popped byte (00h after an empty read) |
| flush | input | 1 | Empty the buffer and clear the overflow error |
| water_lvl | input | 6 | Alert threshold |
| hi_irq_clr | input | 1 | Clear the almost-full interrupt flag |
| lo_irq_clr | input | 1 | Clear the almost-empty interrupt flag |
| level | output | 7 | Number of stored bytes |
| empty | output | 1 | Buffer holds no bytes |
| full | output | 1 | Buffer holds 64 bytes |
| hi_alert | output | 1 | Almost-full alert |
| lo_alert | output | 1 | Almost-empty alert |
| hi_irq | output | 1 | Almost-full interrupt flag |
| lo_irq | output | 1 | Almost-empty interrupt flag |
| ovfl_err | output | 1 | Sticky overflow error |

## Verification
The assertions assume that the strobes are clean, single-cycle levels sampled at the rising edge. They also assume that water_lvl may change at any time, since the alerts are combinational on it. The properties on empty-read and full-write take their own antecedents on the other strobe, so any mix of inputs stays legal. The stimulus changes inputs only just after an edge and releases them after one cycle. It fills the buffer to exactly 64 bytes to reach the full corners, and it asserts flush together with both data strobes to show that flush takes priority.

// File: rtl/fifo_alert_pkg.sv
package fifo_alert_pkg;

    localparam int unsigned FIFO_DEPTH = 64;
    localparam int unsigned BYTE_W     = 8;

    // Per-cycle control decoded at the top and shared by the submodules.
    typedef struct packed {
        logic push;     // accepted write
        logic pop;      // accepted read of a stored byte
        logic drain;    // read of an empty buffer, yields zero
        logic ovf_set;  // write refused because buffer is full
        logic flush;    // empty buffer, clear error
    } fifo_ops_t;

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/fifo_store.sv
module fifo_store
    import fifo_alert_pkg::*;
#(
    parameter int unsigned DEPTH  = FIFO_DEPTH,
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  fifo_ops_t         ops,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PTR_W = ptr_bits(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (ops.push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            rdata <= '0;
        end else if (ops.flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (ops.push) wptr <= bump(wptr);
            if (ops.pop) begin
                rdata <= mem[rptr];
                rptr  <= bump(rptr);
            end else if (ops.drain) begin
                rdata <= '0;
            end
        end
    end

endmodule

// File: rtl/fifo_level.sv
module fifo_level
    import fifo_alert_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned LVL_W = cnt_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_ops_t        ops,
    output logic [LVL_W-1:0] level,
    output logic             ovf
);
    always_ff @(posedge clk) begin
        if (rst || ops.flush) begin
            level <= '0;
        end else begin
            unique case ({ops.push, ops.pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ops.flush) ovf <= 1'b0;
        else if (ops.ovf_set) ovf <= 1'b1;
    end

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ops.flush) |=> ovf);

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ops.flush |=> (level == '0 && !ovf));

endmodule

// File: rtl/fifo_alert.sv
module fifo_alert
    import fifo_alert_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned PTR_W = ptr_bits(DEPTH),
    parameter int unsigned LVL_W = cnt_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [PTR_W-1:0] water,
    input  logic             hi_clr,
    input  logic             lo_clr,
    output logic             hi_alert,
    output logic             lo_alert,
    output logic             hi_irq,
    output logic             lo_irq
);
    localparam int unsigned NCH = 2;

    logic [LVL_W-1:0] free_cnt;
    logic [LVL_W-1:0] water_x;
    logic [NCH-1:0]   alert_v, clr_v, irq_v;

    assign water_x  = LVL_W'(water);
    assign free_cnt = LVL_W'(DEPTH) - level;
    assign hi_alert = (free_cnt <= water_x);
    assign lo_alert = (level <= water_x);

    assign alert_v = {lo_alert, hi_alert};
    assign clr_v   = {lo_clr, hi_clr};
    assign hi_irq  = irq_v[0];
    assign lo_irq  = irq_v[1];

    for (genvar k = 0; k < NCH; k++) begin : g_irq
        logic prev_r, irq_r;
        always_ff @(posedge clk) begin
            prev_r <= alert_v[k];
            if (rst) irq_r <= 1'b0;
            else if (alert_v[k] && !prev_r) irq_r <= 1'b1;
            else if (clr_v[k]) irq_r <= 1'b0;
        end
        assign irq_v[k] = irq_r;

        assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(alert_v[k]) |=> irq_v[k]);
        assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (irq_v[k] && !clr_v[k]) |=> irq_v[k]);
        assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
            (clr_v[k] && !$rose(alert_v[k])) |=> !irq_v[k]);
    end

endmodule

// File: rtl/txrx_byte_fifo.sv
module txrx_byte_fifo
    import fifo_alert_pkg::*;
#(
    parameter int unsigned DEPTH  = FIFO_DEPTH,
    parameter int unsigned DATA_W = BYTE_W,
    parameter int unsigned PTR_W  = ptr_bits(DEPTH),
    parameter int unsigned LVL_W  = cnt_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              flush,
    input  logic [PTR_W-1:0]  water_lvl,
    input  logic              hi_irq_clr,
    input  logic              lo_irq_clr,
    output logic [LVL_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              hi_alert,
    output logic              lo_alert,
    output logic              hi_irq,
    output logic              lo_irq,
    output logic              ovfl_err
);
    fifo_ops_t ops;

    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));

    always_comb begin
        ops         = '0;
        ops.flush   = flush;
        ops.push    = wr_en && !full  && !flush;
        ops.ovf_set = wr_en &&  full  && !flush;
        ops.pop     = rd_en && !empty && !flush;
        ops.drain   = rd_en &&  empty && !flush;
    end

    fifo_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .ops(ops), .wdata(wr_data), .rdata(rd_data)
    );

    fifo_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
        .clk(clk), .rst(rst), .ops(ops), .level(level), .ovf(ovfl_err)
    );

    fifo_alert #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_alert (
        .clk(clk), .rst(rst), .level(level), .water(water_lvl),
        .hi_clr(hi_irq_clr), .lo_clr(lo_irq_clr),
        .hi_alert(hi_alert), .lo_alert(lo_alert),
        .hi_irq(hi_irq), .lo_irq(lo_irq)
    );

    assert_full_write_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en && !flush) |=> (full && ovfl_err));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && empty && !flush) |=> (empty && rd_data == '0));

    assert_simul_level_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && !empty && !full && !flush) |=> $stable(level));

endmodule

// File: tb/sim_txrx_byte_fifo.sv
module sim_txrx_byte_fifo;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 0, rd_en = 0, flush = 0, hi_irq_clr = 0, lo_irq_clr = 0;
    logic [7:0] wr_data = 0;
    logic [5:0] water_lvl = 6'd4;
    logic [7:0] rd_data;
    logic [6:0] level;
    logic       empty, full, hi_alert, lo_alert, hi_irq, lo_irq, ovfl_err;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    txrx_byte_fifo u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .flush(flush), .water_lvl(water_lvl),
        .hi_irq_clr(hi_irq_clr), .lo_irq_clr(lo_irq_clr), .level(level),
        .empty(empty), .full(full), .hi_alert(hi_alert), .lo_alert(lo_alert),
        .hi_irq(hi_irq), .lo_irq(lo_irq), .ovfl_err(ovfl_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock of stimulus; inputs are released one time unit after the edge.
    task automatic op(input bit w, input logic [7:0] d, input bit r, input bit f);
        wr_en = w; wr_data = d; rd_en = r; flush = f;
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; flush = 0; hi_irq_clr = 0; lo_irq_clr = 0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R1", "level", level, 0);
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "ovfl_err", ovfl_err, 0);
        chk("R1", "hi_irq", hi_irq, 0);
        chk("R1", "lo_irq", lo_irq, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R3", "lo_alert at level 0", lo_alert, 1);
        chk("R3", "hi_alert at level 0", hi_alert, 0);
    endtask

    task automatic t_order;
        for (int i = 0; i < 10; i++) op(1, 8'(i * 7 + 3), 0, 0);
        chk("R2", "level after 10 writes", level, 10);
        for (int i = 0; i < 10; i++) begin
            op(0, 0, 1, 0);
            chk("R2", "read order", rd_data, (i * 7 + 3) & 8'hff);
        end
        chk("R2", "empty after drain", empty, 1);
    endtask

    task automatic t_empty_read;
        op(0, 0, 1, 0);
        chk("R7", "rd_data on empty read", rd_data, 0);
        chk("R7", "level on empty read", level, 0);
    endtask

    task automatic t_alerts;
        water_lvl = 6'd4;
        for (int i = 0; i < 4; i++) op(1, 8'h11, 0, 0);
        chk("R3", "lo_alert at level 4", lo_alert, 1);
        op(1, 8'h11, 0, 0);
        chk("R3", "lo_alert at level 5", lo_alert, 0);
        for (int i = 5; i < 59; i++) op(1, 8'h22, 0, 0);
        chk("R3", "hi_alert at level 59", hi_alert, 0);
        op(1, 8'h22, 0, 0);
        chk("R3", "hi_alert at level 60", hi_alert, 1);
        water_lvl = 6'd0; #1;
        chk("R3", "hi_alert water 0 level 60", hi_alert, 0);
        water_lvl = 6'd10; #1;
        chk("R3", "lo_alert water 10 level 60", lo_alert, 0);
        chk("R3", "hi_alert water 10 level 60", hi_alert, 1);
        water_lvl = 6'd4;
        op(0, 0, 0, 1);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < 64; i++) op(1, 8'(i + 8'h40), 0, 0);
        chk("R2", "full at 64", full, 1);
        chk("R4", "ovfl_err before overflow", ovfl_err, 0);
        op(1, 8'hEE, 0, 0);
        chk("R4", "level after write to full", level, 64);
        chk("R4", "ovfl_err after write to full", ovfl_err, 1);
        op(0, 0, 0, 0);
        chk("R5", "ovfl_err after idle", ovfl_err, 1);
        op(1, 8'h55, 1, 0);
        chk("R4", "level after read+write when full", level, 63);
        chk("R4", "rd_data oldest", rd_data, 8'h40);
        for (int i = 1; i < 64; i++) begin
            op(0, 0, 1, 0);
            chk("R4", "stored byte intact", rd_data, i + 8'h40);
        end
        chk("R4", "empty after drain", empty, 1);
        chk("R5", "ovfl_err after drain", ovfl_err, 1);
    endtask

    task automatic t_flush;
        for (int i = 0; i < 3; i++) op(1, 8'h99, 0, 0);
        op(1, 8'h77, 1, 1);
        chk("R6", "level after flush", level, 0);
        chk("R6", "ovfl_err after flush", ovfl_err, 0);
        chk("R6", "rd_data unchanged by ignored read", rd_data, 8'h7f);
        op(1, 8'h3C, 0, 0);
        op(0, 0, 1, 0);
        chk("R6", "first byte after flush", rd_data, 8'h3C);
        chk("R6", "empty after flush and reuse", empty, 1);
    endtask

    task automatic t_simul;
        op(1, 8'h01, 0, 0);
        op(1, 8'h02, 0, 0);
        op(1, 8'h03, 0, 0);
        op(1, 8'h09, 1, 0);
        chk("R8", "level on read+write", level, 3);
        chk("R8", "rd_data on read+write", rd_data, 1);
        op(0, 0, 1, 0); chk("R8", "second byte", rd_data, 2);
        op(0, 0, 1, 0); chk("R8", "third byte", rd_data, 3);
        op(0, 0, 1, 0); chk("R8", "appended byte", rd_data, 9);
    endtask

    task automatic t_irq;
        lo_irq_clr = 1; hi_irq_clr = 1;
        op(0, 0, 0, 0);
        chk("R9", "lo_irq cleared", lo_irq, 0);
        chk("R9", "hi_irq cleared", hi_irq, 0);
        for (int i = 0; i < 5; i++) op(1, 8'h5A, 0, 0);
        op(0, 0, 1, 0);
        chk("R9", "lo_irq same edge as level change", lo_irq, 0);
        op(0, 0, 0, 0);
        chk("R9", "lo_irq one edge after alert rise", lo_irq, 1);
        op(0, 0, 0, 0);
        chk("R9", "lo_irq held", lo_irq, 1);
        lo_irq_clr = 1;
        op(0, 0, 0, 0);
        chk("R9", "lo_irq after clear", lo_irq, 0);
        op(1, 8'h5A, 0, 0);
        lo_irq_clr = 1;
        op(0, 0, 1, 0);
        lo_irq_clr = 1;
        op(0, 0, 0, 0);
        chk("R9", "rise beats clear", lo_irq, 1);
        for (int i = 4; i < 60; i++) op(1, 8'h6B, 0, 0);
        op(0, 0, 0, 0);
        chk("R9", "hi_irq after fill to 60", hi_irq, 1);
        op(0, 0, 0, 1);
    endtask

    initial begin
        #1000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        t_reset;
        t_order;
        t_empty_read;
        t_alerts;
        t_overflow;
        op(1, 8'h7f, 0, 0);
        op(0, 0, 1, 0);
        t_flush;
        t_simul;
        t_irq;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule